// File: doc/BRIEF.md
# Saturating Multi-Operation Function Unit

This block is a purely combinational 16-bit function unit, meant to be placed several times side by side in the first stage of a wide arithmetic datapath. Each copy takes two operands, a 5-bit operation code and a number-format select. It returns one result word and an overflow indication. All of these settle within the same cycle, because the unit holds no registers.

The operation menu covers several groups:
- wrapping and clamping add and subtract
- negation and absolute value
- the four bitwise logic operations
- signed minimum and maximum
- left and right shifts
- a small constant generator that drives 0, 1, -1 or -2 without looking at the operands

The format select chooses between integer and fixed-point (Q1.15) behaviour, and only the shifts depend on it. In fixed-point mode a right shift keeps the sign and a left shift clamps instead of wrapping. In integer mode a right shift fills with zeros and a left shift drops bits.

Top module: `fu_core`

## Requirements
- R1: Code 0 returns op_a + op_b and code 1 returns op_a - op_b, both modulo 2^16.
- R2: `overflow` is 1 only for codes 0, 1 and 4, and only when the signed two's-complement result wraps. For every other code it is 0.
- R3: Codes 2 (add) and 3 (op_a - op_b) treat operands as signed. A result above 32767 becomes 0x7FFF and a result below -32768 becomes 0x8000.
- R4: Code 4 returns the two's-complement negation of op_a. An input of 0x8000 returns 0x8000 with `overflow` set.
- R5: Codes 5, 6 and 7 return bitwise AND, OR and XOR of the operands. Code 8 returns the bitwise inverse of op_a.
- R6: Codes 11 (minimum) and 12 (maximum) compare the operands as signed values.
- R7: Code 13 returns the absolute value of signed op_a, and 0x8000 returns 0x7FFF.
- R8: Code 9 shifts op_a left by op_b[3:0]. With `fixed_mode`=0 the bits shifted out are lost. With `fixed_mode`=1 a result that cannot hold the signed product op_a*2^n clamps to 0x7FFF or 0x8000.
- R9: Code 10 shifts op_a right by op_b[3:0]. It is logical with `fixed_mode`=0 and arithmetic with `fixed_mode`=1.
- R10: Codes 14, 15, 16 and 17 return 0x0000, 0x0001, 0xFFFF and 0xFFFE whatever the operands are.
- R11: Codes 18 to 31 return 0x0000.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_a | input | 16 | First operand |
| op_b | input | 16 | Second operand; its low 4 bits give the shift distance |
| opcode | input | 5 | Operation select |
| fixed_mode | input | 1 | 1 = fixed-point (Q1.15), 0 = integer |
| result | output | 16 | Selected result |
| overflow | output | 1 | Signed wrap of add, subtract or negate |

## Verification
The arithmetic codes are driven with operand pairs that sit just inside and just outside the signed range. This separates a correct clamp from a wrap, and separates the two ways overflow can be detected. Shifts are run on negative and positive values at distances 0, 1 and 15 in both formats. This exposes a swapped fill bit and a clamp applied in the wrong mode. Minimum and maximum use pairs that differ in sign, where an unsigned compare would give the wrong answer. A pseudo-random sweep over all 32 codes, compared against a bench model, catches crossed selection legs and codes that leak into the unused range.

// File: rtl/fu_pkg.sv
// Shared definitions for the function unit: the operation code type.
// Assumes a 5-bit opcode field; codes not listed decode to a zero result.
package fu_pkg;
    localparam int OPW = 5;

    typedef enum logic [OPW-1:0] {
        OP_ADD  = 5'd0,
        OP_SUB  = 5'd1,
        OP_ADDS = 5'd2,
        OP_SUBS = 5'd3,
        OP_NEG  = 5'd4,
        OP_AND  = 5'd5,
        OP_OR   = 5'd6,
        OP_XOR  = 5'd7,
        OP_NOT  = 5'd8,
        OP_SHL  = 5'd9,
        OP_SHR  = 5'd10,
        OP_MIN  = 5'd11,
        OP_MAX  = 5'd12,
        OP_ABS  = 5'd13,
        OP_K0   = 5'd14,
        OP_K1   = 5'd15,
        OP_KM1  = 5'd16,
        OP_KM2  = 5'd17
    } fu_op_e;

    localparam logic [OPW-1:0] OP_LAST = 5'd17;
endpackage

// File: rtl/fu_addsub.sv
// Shared adder for add, subtract and negate. It returns the wrapped sum, a
// clamped copy of the sum, and the signed-wrap flag.
// Assumes: negate is computed as 0 - a; subtract is computed as a + ~b + 1.
module fu_addsub #(
    parameter int W = 16
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         do_sub,
    input  logic         do_neg,
    output logic [W-1:0] wrap_sum,
    output logic [W-1:0] sat_sum,
    output logic         wrapped
);
    localparam logic [W-1:0] SMAX = {1'b0, {(W-1){1'b1}}};
    localparam logic [W-1:0] SMIN = {1'b1, {(W-1){1'b0}}};

    logic [W-1:0] x, y, y_eff;
    logic         cin;

    // Choose the adder inputs for add, subtract or negate.
    always_comb begin
        x     = do_neg ? '0 : a;
        y     = do_neg ? a  : b;
        cin   = do_sub | do_neg;
        y_eff = cin ? ~y : y;
    end

    // Form the sum, detect a signed wrap, and build the clamped value.
    always_comb begin
        wrap_sum = x + y_eff + {{(W-1){1'b0}}, cin};
        wrapped  = (x[W-1] == y_eff[W-1]) && (wrap_sum[W-1] != x[W-1]);
        sat_sum  = wrapped ? (x[W-1] ? SMIN : SMAX) : wrap_sum;
    end
endmodule

// File: rtl/fu_shift.sv
// Barrel shifter. The shift distance is the low log2(W) bits of amt.
// Fixed-point mode: right shifts are arithmetic and left shifts clamp.
// Integer mode: right shifts are logical and left shifts wrap.
module fu_shift #(
    parameter int W = 16
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] amt,
    input  logic         fixed_mode,
    output logic [W-1:0] shl,
    output logic [W-1:0] shr
);
    localparam int SHW = $clog2(W);
    localparam logic [W-1:0] SMAX = {1'b0, {(W-1){1'b1}}};
    localparam logic [W-1:0] SMIN = {1'b1, {(W-1){1'b0}}};

    logic [SHW-1:0] n;
    logic [2*W-1:0] wide;
    logic [W:0]     upper;
    logic           fits;

    // Left shift on a sign-extended copy; the value fits if the upper bits all match the sign.
    always_comb begin
        n     = amt[SHW-1:0];
        wide  = {{W{a[W-1]}}, a} << n;
        upper = wide[2*W-1:W-1];
        fits  = (&upper) | ~(|upper);
        if (fixed_mode && !fits)
            shl = a[W-1] ? SMIN : SMAX;
        else
            shl = wide[W-1:0];
    end

    // Right shift, filling with the sign bit in fixed-point mode and with zeros otherwise.
    always_comb begin
        if (fixed_mode)
            shr = W'($signed(a) >>> n);
        else
            shr = a >> n;
    end
endmodule

// File: rtl/fu_cmp.sv
// Signed comparison logic for minimum, maximum and absolute value.
// Assumes two's-complement operands; the absolute value of the most
// negative number clamps to the most positive one.
module fu_cmp #(
    parameter int W = 16
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] vmin,
    output logic [W-1:0] vmax,
    output logic [W-1:0] vabs
);
    localparam logic [W-1:0] SMAX = {1'b0, {(W-1){1'b1}}};
    localparam logic [W-1:0] SMIN = {1'b1, {(W-1){1'b0}}};

    logic a_lt_b;

    // Signed compare feeding both selectors.
    always_comb begin
        a_lt_b = $signed(a) < $signed(b);
        vmin   = a_lt_b ? a : b;
        vmax   = a_lt_b ? b : a;
    end

    // Absolute value with a clamp for the most negative input.
    always_comb begin
        if (!a[W-1])
            vabs = a;
        else if (a == SMIN)
            vabs = SMAX;
        else
            vabs = -a;
    end
endmodule

// File: rtl/fu_core.sv
// Combinational multi-operation function unit (top level).
// It decodes the opcode, runs the operand pair through the adder, shifter
// and compare blocks, and picks one result. Assumes no clock: every output
// follows the inputs within the same cycle.
module fu_core
    import fu_pkg::*;
#(
    parameter int W = 16
) (
    input  logic [W-1:0]   op_a,
    input  logic [W-1:0]   op_b,
    input  logic [OPW-1:0] opcode,
    input  logic           fixed_mode,
    output logic [W-1:0]   result,
    output logic           overflow
);
    localparam logic [W-1:0] K_ONE  = {{(W-1){1'b0}}, 1'b1};
    localparam logic [W-1:0] K_MONE = {W{1'b1}};
    localparam logic [W-1:0] K_MTWO = {{(W-1){1'b1}}, 1'b0};

    fu_op_e       op;
    logic         do_sub, do_neg, wrapped;
    logic [W-1:0] wrap_sum, sat_sum, shl, shr, vmin, vmax, vabs;

    // Decode the opcode into adder controls.
    always_comb begin
        op     = fu_op_e'(opcode);
        do_sub = (op == OP_SUB) || (op == OP_SUBS);
        do_neg = (op == OP_NEG);
    end

    fu_addsub #(.W(W)) u_addsub (
        .a(op_a), .b(op_b), .do_sub(do_sub), .do_neg(do_neg),
        .wrap_sum(wrap_sum), .sat_sum(sat_sum), .wrapped(wrapped)
    );

    fu_shift #(.W(W)) u_shift (
        .a(op_a), .amt(op_b), .fixed_mode(fixed_mode), .shl(shl), .shr(shr)
    );

    fu_cmp #(.W(W)) u_cmp (
        .a(op_a), .b(op_b), .vmin(vmin), .vmax(vmax), .vabs(vabs)
    );

    // Result selector; codes outside the menu give zero.
    always_comb begin
        overflow = 1'b0;
        unique case (op)
            OP_ADD, OP_SUB, OP_NEG: begin
                result   = wrap_sum;
                overflow = wrapped;
            end
            OP_ADDS, OP_SUBS: result = sat_sum;
            OP_AND:  result = op_a & op_b;
            OP_OR:   result = op_a | op_b;
            OP_XOR:  result = op_a ^ op_b;
            OP_NOT:  result = ~op_a;
            OP_SHL:  result = shl;
            OP_SHR:  result = shr;
            OP_MIN:  result = vmin;
            OP_MAX:  result = vmax;
            OP_ABS:  result = vabs;
            OP_K0:   result = '0;
            OP_K1:   result = K_ONE;
            OP_KM1:  result = K_MONE;
            OP_KM2:  result = K_MTWO;
            default: result = '0;
        endcase
    end

    // Checks on the selected result against the operands.
    always_comb begin
        // R2: the overflow flag is only raised by the wrapping arithmetic codes
        a_r2_ovf_scope: assert (!overflow || op == OP_ADD || op == OP_SUB || op == OP_NEG);
        // R3: a clamping add of two same-sign operands keeps that sign
        if (op == OP_ADDS && op_a[W-1] == op_b[W-1])
            a_r3_sat_sign: assert (result[W-1] == op_a[W-1]);
        // R6: the minimum never exceeds either operand
        if (op == OP_MIN)
            a_r6_min_bound: assert ($signed(result) <= $signed(op_a) && $signed(result) <= $signed(op_b));
        // R7: the absolute value is never negative
        if (op == OP_ABS)
            a_r7_abs_nonneg: assert (!result[W-1]);
        // R11: unused codes produce zero without overflow
        if (opcode > OP_LAST)
            a_r11_unused_zero: assert (result == '0 && !overflow);
    end
endmodule

// File: tb/fu_core_test.sv
// Directed bench for fu_core. Each task drives one scenario and checks
// every vector against a behavioural model computed with integers.
module fu_core_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] a, b;
    logic [4:0]  opc;
    logic        fx;
    logic [15:0] result;
    logic        overflow;

    int vectors = 0;
    int fails   = 0;
    int cycles  = 0;

    always #2.5 clk = ~clk;   // 200 MHz

    fu_core uut (
        .op_a(a), .op_b(b), .opcode(opc), .fixed_mode(fx),
        .result(result), .overflow(overflow)
    );

    // Watchdog: a hung run counts as a failure and still prints the summary.
    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 100000) begin
            fails = fails + 1;
            $display("FAIL watchdog expired");
            $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

    function automatic int clampv(int v);
        if (v > 32767)  return 32767;
        if (v < -32768) return -32768;
        return v;
    endfunction

    // Behavioural model: returns {overflow, result}.
    function automatic logic [16:0] model(logic [15:0] x, logic [15:0] y, logic [4:0] c, logic f);
        int sx = int'($signed(x));
        int sy = int'($signed(y));
        int s  = int'(y[3:0]);
        int v  = 0;
        logic o = 1'b0;
        case (c)
            5'd0:  begin v = sx + sy; o = (v > 32767 || v < -32768); end
            5'd1:  begin v = sx - sy; o = (v > 32767 || v < -32768); end
            5'd2:  v = clampv(sx + sy);
            5'd3:  v = clampv(sx - sy);
            5'd4:  begin v = -sx; o = (v > 32767); end
            5'd5:  v = int'(x & y);
            5'd6:  v = int'(x | y);
            5'd7:  v = int'(x ^ y);
            5'd8:  v = int'(~x);
            5'd9:  v = f ? clampv(sx * (1 << s)) : (int'(x) << s);
            5'd10: v = f ? (sx >>> s) : (int'(x) >> s);
            5'd11: v = (sx < sy) ? sx : sy;
            5'd12: v = (sx > sy) ? sx : sy;
            5'd13: v = clampv(sx < 0 ? -sx : sx);
            5'd14: v = 0;
            5'd15: v = 1;
            5'd16: v = -1;
            5'd17: v = -2;
            default: v = 0;
        endcase
        return {o, v[15:0]};
    endfunction

    task automatic apply(input logic [15:0] x, input logic [15:0] y, input logic [4:0] c,
                         input logic f, input string req);
        logic [16:0] exp;
        @(negedge clk);
        a = x; b = y; opc = c; fx = f;
        @(posedge clk);
        #1;
        exp = model(x, y, c, f);
        vectors = vectors + 1;
        if ({overflow, result} !== exp) begin
            fails = fails + 1;
            $display("FAIL %s op=%0d a=%h b=%h fx=%0b: got res=%h ovf=%0b, expected res=%h ovf=%0b",
                     req, c, x, y, f, result, overflow, exp[15:0], exp[16]);
        end
    endtask

    task automatic t_idle;
        apply(16'h0000, 16'h0000, 5'd0, 1'b0, "R1 idle");
    endtask

    task automatic t_wrap_arith;   // R1 and R2
        apply(16'h1234, 16'h0FF0, 5'd0, 1'b0, "R1 add");
        apply(16'h7FFF, 16'h0001, 5'd0, 1'b0, "R2 add wrap");
        apply(16'h8000, 16'hFFFF, 5'd0, 1'b0, "R2 add neg wrap");
        apply(16'hFFFF, 16'h0001, 5'd0, 1'b0, "R2 unsigned carry no ovf");
        apply(16'h0005, 16'h0007, 5'd1, 1'b0, "R1 sub");
        apply(16'h8000, 16'h0001, 5'd1, 1'b0, "R2 sub wrap");
        apply(16'h0000, 16'h8000, 5'd1, 1'b0, "R2 sub min wrap");
    endtask

    task automatic t_sat;          // R3
        apply(16'h7000, 16'h2000, 5'd2, 1'b0, "R3 adds pos clamp");
        apply(16'h9000, 16'hE000, 5'd2, 1'b0, "R3 adds neg clamp");
        apply(16'h7FFE, 16'h0001, 5'd2, 1'b0, "R3 adds edge");
        apply(16'h8000, 16'h0001, 5'd3, 1'b0, "R3 subs neg clamp");
        apply(16'h7FFF, 16'hFFFF, 5'd3, 1'b0, "R3 subs pos clamp");
        apply(16'h0010, 16'h0020, 5'd3, 1'b0, "R3 subs normal");
    endtask

    task automatic t_neg;          // R4
        apply(16'h0003, 16'h1111, 5'd4, 1'b0, "R4 neg");
        apply(16'h8000, 16'h0000, 5'd4, 1'b0, "R4 neg min");
        apply(16'h0000, 16'h0000, 5'd4, 1'b0, "R4 neg zero");
    endtask

    task automatic t_logic;        // R5
        for (int c = 5; c <= 8; c++) apply(16'hF0CC, 16'h3A5F, 5'(c), 1'b0, "R5 logic");
    endtask

    task automatic t_minmax;       // R6 and R7
        apply(16'hFFFF, 16'h0001, 5'd11, 1'b0, "R6 min sign");
        apply(16'hFFFF, 16'h0001, 5'd12, 1'b0, "R6 max sign");
        apply(16'h8000, 16'h7FFF, 5'd11, 1'b1, "R6 min extremes");
        apply(16'h0042, 16'h0042, 5'd12, 1'b0, "R6 max equal");
        apply(16'hFFF6, 16'h0000, 5'd13, 1'b0, "R7 abs neg");
        apply(16'h8000, 16'h0000, 5'd13, 1'b0, "R7 abs min");
        apply(16'h1234, 16'h0000, 5'd13, 1'b0, "R7 abs pos");
    endtask

    task automatic t_shift;        // R8 and R9
        for (int f = 0; f < 2; f++) begin
            apply(16'hC001, 16'h0000, 5'd9,  1'(f), "R8 shl 0");
            apply(16'h4001, 16'h0001, 5'd9,  1'(f), "R8 shl pos over");
            apply(16'hC001, 16'h0001, 5'd9,  1'(f), "R8 shl neg fits");
            apply(16'h8001, 16'h0001, 5'd9,  1'(f), "R8 shl neg over");
            apply(16'h0001, 16'hFFFF, 5'd9,  1'(f), "R8 shl 15");
            apply(16'hFFFF, 16'h0010, 5'd9,  1'(f), "R8 shl amt low bits");
            apply(16'h8010, 16'h0004, 5'd10, 1'(f), "R9 shr neg");
            apply(16'h8000, 16'h000F, 5'd10, 1'(f), "R9 shr 15");
            apply(16'h7FF0, 16'h0003, 5'd10, 1'(f), "R9 shr pos");
        end
    endtask

    task automatic t_const;        // R10
        for (int c = 14; c <= 17; c++) begin
            apply(16'hA5A5, 16'h5A5A, 5'(c), 1'b0, "R10 const");
            apply(16'h8000, 16'h7FFF, 5'(c), 1'b1, "R10 const");
        end
    endtask

    task automatic t_unused;       // R11
        for (int c = 18; c < 32; c++) apply(16'h7FFF, 16'h7FFF, 5'(c), 1'b1, "R11 unused");
    endtask

    task automatic t_sweep;        // R1 to R11 under pseudo-random operands
        logic [31:0] lfsr = 32'hACE1_1234;
        for (int i = 0; i < 640; i++) begin
            lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
            apply(lfsr[15:0], lfsr[31:16] ^ 16'(i * 37), 5'(i % 32), lfsr[7], "sweep");
        end
    endtask

    initial begin
        a = '0; b = '0; opc = '0; fx = 1'b0;
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        t_idle();
        t_wrap_arith();
        t_sat();
        t_neg();
        t_logic();
        t_minmax();
        t_shift();
        t_const();
        t_unused();
        t_sweep();
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule